// File: doc/BRIEF.md
# Compute-in-Memory Custom Instruction Unit

This unit sits in the execute stage of a small processor. It carries out the three operations of one custom major opcode that drive a compute-in-memory array. Each operation moves data only between on-chip memories and the array, and never touches the register file. A convolution reads a feature-map word and shifts it into the array input buffer. It then fires the array evaluation and writes the array result back into the feature-map SRAM. An array read copies a weight word from the array into the weight SRAM. An array write copies one 32-bit word from the weight SRAM into the array.

Both addresses come from a base register value plus a sign-extended immediate. The source uses rs1 and the destination uses rs2. Every strobe of one operation is raised in the same cycle, so an unstalled instruction finishes in the cycle in which it is presented. If the SRAM arbiter stalls the unit, the accepted operation and its two addresses are captured. The unit then reports busy and fires the captured operation in the first cycle without a stall.

Top module: `cim_op_unit`

## Requirements
- R1: Only an instruction whose 7-bit opcode equals 7'b1111110 is acted on. When the unit is idle, any other opcode, or a low instrValid, raises no strobe, no doneOut and no illegalOut.
- R2: The source address is rs1Val plus immSrcIn sign-extended from 7 bits. The destination address is rs2Val plus immDstIn sign-extended from 5 bits. Both sums wrap modulo the depth of the memory they address.
- R3: funct3 = 3'b000 (convolution) raises fmRdEn at the source address, arrPushEn with arrInData equal to fmRdData, arrEvalEn, and fmWrEn at the destination address with fmWrData equal to arrResult, all in one cycle.
- R4: funct3 = 3'b001 (array read) raises arrRdEn with arrAddr at the source address, and wtWrEn at the destination address with wtWrData equal to arrRdData, in one cycle.
- R5: funct3 = 3'b010 (array write) raises wtRdEn at the source address, and arrWrEn with arrAddr at the destination address and arrWrData equal to the 32-bit wtRdData, in one cycle.
- R6: Any other funct3 under the custom opcode raises illegalOut in the same cycle, whether or not stallIn is high. It raises no strobe and no doneOut, and leaves busyOut low.
- R7: While stallIn is high, every strobe and doneOut stay low. A legal instruction accepted under stall sets busyOut from the next cycle.
- R8: While busyOut is high, the instruction inputs are ignored. In the first cycle with stallIn low, the captured operation fires with its captured addresses and doneOut is raised. busyOut falls in the following cycle.
- R9: doneOut is high exactly in the cycle in which an operation fires, and in that cycle the strobes of exactly one operation are raised.
- R10: Reset clears busyOut and discards any captured operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| instrValid | input | 1 | Instruction fields are valid this cycle |
| opcodeIn | input | 7 | Major opcode field |
| funct3In | input | 3 | Operation select field |
| immSrcIn | input | 7 | Source offset field, instruction bits 31:25 |
| immDstIn | input | 5 | Destination offset field, instruction bits 11:7 |
| rs1Val | input | AW | Low bits of the source base register value |
| rs2Val | input | AW | Low bits of the destination base register value |
| stallIn | input | 1 | SRAM arbiter stall |
| doneOut | output | 1 | An operation fires this cycle |
| illegalOut | output | 1 | Unsupported funct3 under the custom opcode |
| busyOut | output | 1 | A stalled operation is held |
| fmRdEn | output | 1 | Feature-map SRAM read strobe |
| fmRdAddr | output | FM_AW | Feature-map read address |
| fmRdData | input | DW | Feature-map read data |
| fmWrEn | output | 1 | Feature-map SRAM write strobe |
| fmWrAddr | output | FM_AW | Feature-map write address |
| fmWrData | output | DW | Feature-map write data |
| wtRdEn | output | 1 | Weight SRAM read strobe |
| wtRdAddr | output | WT_AW | Weight read address |
| wtRdData | input | DW | Weight read data |
| wtWrEn | output | 1 | Weight SRAM write strobe |
| wtWrAddr | output | WT_AW | Weight write address |
| wtWrData | output | DW | Weight write data |
| arrPushEn | output | 1 | Shift a word into the array input buffer |
| arrInData | output | DW | Word for the array input buffer |
| arrEvalEn | output | 1 | Fire the array multiply-accumulate |
| arrResult | input | DW | Array evaluation result |
| arrRdEn | output | 1 | Array weight read strobe |
| arrWrEn | output | 1 | Array weight write strobe |
| arrAddr | output | ARR_AW | Array weight address |
| arrRdData | input | DW | Array weight read data |
| arrWrData | output | DW | Array weight write data |

## Verification
Two events can fall in the same cycle: the release of a stall that is holding a captured operation, and a different new instruction presented on the inputs. The bench captures a convolution under stall. It then presents an array write with other addresses and holds the stall for several cycles before dropping it. In the release cycle, the strobes and addresses must be those of the captured convolution. The waiting array write must fire only in the next cycle, once busyOut has fallen. Every opcode, funct3 and immediate sign pattern is also swept against base values near zero and near the top of the address range, so that wrap in both directions is compared with sums computed in the bench.

// File: rtl/cim_op_pkg.sv
package cim_op_pkg;

  localparam logic [6:0] CIM_OPCODE = 7'b1111110;

  typedef enum logic [1:0] {
    OP_CONV = 2'd0,
    OP_ARD  = 2'd1,
    OP_AWR  = 2'd2
  } cim_op_e;

  // Enables that leave the block toward the memories and the array.
  typedef struct packed {
    logic fmRd;
    logic fmWr;
    logic wtRd;
    logic wtWr;
    logic arrPush;
    logic arrEval;
    logic arrRd;
    logic arrWr;
  } cim_en_t;

  // Control handed to the datapath.
  typedef struct packed {
    logic capture;
    logic useHeld;
    logic arrFromSrc;
  } cim_dpctl_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cim_op_ctrl.sv
module cim_op_ctrl
  import cim_op_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrValid,
  input  logic [6:0] opcodeIn,
  input  logic [2:0] funct3In,
  input  logic       stallIn,
  output cim_en_t    en,
  output cim_dpctl_t dpc,
  output logic       doneOut,
  output logic       illegalOut,
  output logic       busyOut
);

  logic    pendQ;
  cim_op_e heldOpQ;
  logic    cimHit;
  logic    f3Legal;
  logic    acceptNew;
  logic    fire;
  cim_op_e newOp;
  cim_op_e actOp;

  always_comb begin
    cimHit     = instrValid && !pendQ && (opcodeIn == CIM_OPCODE);
    f3Legal    = (funct3In[2] == 1'b0) && (funct3In[1:0] != 2'b11);
    acceptNew  = cimHit && f3Legal;
    illegalOut = cimHit && !f3Legal;
    newOp      = cim_op_e'(funct3In[1:0]);
    actOp      = pendQ ? heldOpQ : newOp;
    fire       = (pendQ || acceptNew) && !stallIn;

    en = '0;
    if (fire) begin
      case (actOp)
        OP_CONV: begin
          en.fmRd    = 1'b1;
          en.arrPush = 1'b1;
          en.arrEval = 1'b1;
          en.fmWr    = 1'b1;
        end
        OP_ARD: begin
          en.arrRd = 1'b1;
          en.wtWr  = 1'b1;
        end
        OP_AWR: begin
          en.wtRd  = 1'b1;
          en.arrWr = 1'b1;
        end
        default: ;
      endcase
    end

    doneOut        = fire;
    busyOut        = pendQ;
    dpc.capture    = acceptNew && stallIn;
    dpc.useHeld    = pendQ;
    dpc.arrFromSrc = (actOp == OP_ARD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= 1'b0;
      heldOpQ <= OP_CONV;
    end else if (dpc.capture) begin
      pendQ   <= 1'b1;
      heldOpQ <= newOp;
    end else if (pendQ && !stallIn) begin
      pendQ <= 1'b0;
    end
  end

endmodule

// File: rtl/cim_op_dpath.sv
module cim_op_dpath
  import cim_op_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FM_AW  = 8,
  parameter int WT_AW  = 8,
  parameter int ARR_AW = 8,
  localparam int AW    = maxOf3(FM_AW, WT_AW, ARR_AW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cim_dpctl_t        dpc,
  input  logic [6:0]        immSrcIn,
  input  logic [4:0]        immDstIn,
  input  logic [AW-1:0]     rs1Val,
  input  logic [AW-1:0]     rs2Val,
  input  logic [DW-1:0]     fmRdData,
  input  logic [DW-1:0]     wtRdData,
  input  logic [DW-1:0]     arrResult,
  input  logic [DW-1:0]     arrRdData,
  output logic [FM_AW-1:0]  fmRdAddr,
  output logic [FM_AW-1:0]  fmWrAddr,
  output logic [DW-1:0]     fmWrData,
  output logic [WT_AW-1:0]  wtRdAddr,
  output logic [WT_AW-1:0]  wtWrAddr,
  output logic [DW-1:0]     wtWrData,
  output logic [DW-1:0]     arrInData,
  output logic [ARR_AW-1:0] arrAddr,
  output logic [DW-1:0]     arrWrData
);

  logic [AW-1:0] srcSum;
  logic [AW-1:0] dstSum;
  logic [AW-1:0] srcQ;
  logic [AW-1:0] dstQ;
  logic [AW-1:0] srcAddr;
  logic [AW-1:0] dstAddr;

  // Sums are kept at the widest address; truncation per port gives the wrap.
  always_comb begin
    srcSum  = rs1Val + AW'($signed(immSrcIn));
    dstSum  = rs2Val + AW'($signed(immDstIn));
    srcAddr = dpc.useHeld ? srcQ : srcSum;
    dstAddr = dpc.useHeld ? dstQ : dstSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
    end else if (dpc.capture) begin
      srcQ <= srcSum;
      dstQ <= dstSum;
    end
  end

  always_comb begin
    fmRdAddr  = srcAddr[FM_AW-1:0];
    fmWrAddr  = dstAddr[FM_AW-1:0];
    wtRdAddr  = srcAddr[WT_AW-1:0];
    wtWrAddr  = dstAddr[WT_AW-1:0];
    arrAddr   = dpc.arrFromSrc ? srcAddr[ARR_AW-1:0] : dstAddr[ARR_AW-1:0];
    arrInData = fmRdData;
    fmWrData  = arrResult;
    wtWrData  = arrRdData;
    arrWrData = wtRdData;
  end

endmodule

// File: rtl/cim_op_unit.sv
module cim_op_unit
  import cim_op_pkg::*;
#(
  parameter int DW     = 32,
  parameter int FM_AW  = 8,
  parameter int WT_AW  = 8,
  parameter int ARR_AW = 8,
  localparam int AW    = maxOf3(FM_AW, WT_AW, ARR_AW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [6:0]        opcodeIn,
  input  logic [2:0]        funct3In,
  input  logic [6:0]        immSrcIn,
  input  logic [4:0]        immDstIn,
  input  logic [AW-1:0]     rs1Val,
  input  logic [AW-1:0]     rs2Val,
  input  logic              stallIn,
  output logic              doneOut,
  output logic              illegalOut,
  output logic              busyOut,
  output logic              fmRdEn,
  output logic [FM_AW-1:0]  fmRdAddr,
  input  logic [DW-1:0]     fmRdData,
  output logic              fmWrEn,
  output logic [FM_AW-1:0]  fmWrAddr,
  output logic [DW-1:0]     fmWrData,
  output logic              wtRdEn,
  output logic [WT_AW-1:0]  wtRdAddr,
  input  logic [DW-1:0]     wtRdData,
  output logic              wtWrEn,
  output logic [WT_AW-1:0]  wtWrAddr,
  output logic [DW-1:0]     wtWrData,
  output logic              arrPushEn,
  output logic [DW-1:0]     arrInData,
  output logic              arrEvalEn,
  input  logic [DW-1:0]     arrResult,
  output logic              arrRdEn,
  output logic              arrWrEn,
  output logic [ARR_AW-1:0] arrAddr,
  input  logic [DW-1:0]     arrRdData,
  output logic [DW-1:0]     arrWrData
);

  cim_en_t    en;
  cim_dpctl_t dpc;

  cim_op_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .opcodeIn   (opcodeIn),
    .funct3In   (funct3In),
    .stallIn    (stallIn),
    .en         (en),
    .dpc        (dpc),
    .doneOut    (doneOut),
    .illegalOut (illegalOut),
    .busyOut    (busyOut)
  );

  cim_op_dpath #(
    .DW     (DW),
    .FM_AW  (FM_AW),
    .WT_AW  (WT_AW),
    .ARR_AW (ARR_AW)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .dpc       (dpc),
    .immSrcIn  (immSrcIn),
    .immDstIn  (immDstIn),
    .rs1Val    (rs1Val),
    .rs2Val    (rs2Val),
    .fmRdData  (fmRdData),
    .wtRdData  (wtRdData),
    .arrResult (arrResult),
    .arrRdData (arrRdData),
    .fmRdAddr  (fmRdAddr),
    .fmWrAddr  (fmWrAddr),
    .fmWrData  (fmWrData),
    .wtRdAddr  (wtRdAddr),
    .wtWrAddr  (wtWrAddr),
    .wtWrData  (wtWrData),
    .arrInData (arrInData),
    .arrAddr   (arrAddr),
    .arrWrData (arrWrData)
  );

  assign fmRdEn    = en.fmRd;
  assign fmWrEn    = en.fmWr;
  assign wtRdEn    = en.wtRd;
  assign wtWrEn    = en.wtWr;
  assign arrPushEn = en.arrPush;
  assign arrEvalEn = en.arrEval;
  assign arrRdEn   = en.arrRd;
  assign arrWrEn   = en.arrWr;

endmodule

// File: rtl/cim_op_chk.sv
module cim_op_chk (
  input logic       clk,
  input logic       rstN,
  input logic       instrValid,
  input logic [6:0] opcodeIn,
  input logic       stallIn,
  input logic       doneOut,
  input logic       illegalOut,
  input logic       busyOut,
  input logic       fmRdEn,
  input logic       fmWrEn,
  input logic       wtRdEn,
  input logic       wtWrEn,
  input logic       arrPushEn,
  input logic       arrEvalEn,
  input logic       arrRdEn,
  input logic       arrWrEn
);

  logic [7:0] enAll;
  assign enAll = {fmRdEn, fmWrEn, wtRdEn, wtWrEn, arrPushEn, arrEvalEn, arrRdEn, arrWrEn};

  // R1: idle unit ignores anything that is not a valid custom instruction
  a_r1_foreign_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busyOut && !(instrValid && opcodeIn == 7'b1111110)) |-> (enAll == 8'd0 && !doneOut));

  // R3: convolution strobes fire together and complete the operation
  a_r3_conv_atomic: assert property (@(posedge clk) disable iff (!rstN)
    fmRdEn |-> (arrPushEn && arrEvalEn && fmWrEn && doneOut));

  // R4: array read lands in the weight SRAM in the same cycle
  a_r4_read_pair: assert property (@(posedge clk) disable iff (!rstN)
    arrRdEn |-> (wtWrEn && doneOut && !arrWrEn));

  // R5: array write is fed by a weight SRAM read in the same cycle
  a_r5_write_pair: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (wtRdEn && doneOut && !arrRdEn));

  // R6: illegal funct3 produces no activity
  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> (enAll == 8'd0 && !doneOut));

  // R7: stall silences every strobe
  a_r7_stall_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stallIn |-> (enAll == 8'd0 && !doneOut));

  // R8: a held operation fires on release and busy drops afterwards
  a_r8_release_fires: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !stallIn) |-> doneOut);

  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && !stallIn) |=> !busyOut);

  // R9: completion means exactly one operation class is active
  a_r9_one_class: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> ($countones({fmRdEn, arrRdEn, wtRdEn}) == 1));

  a_r9_no_orphan: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> (enAll == 8'd0));

endmodule

bind cim_op_unit cim_op_chk u_chk (.*);

// File: tb/cim_op_unit_bench.sv
module cim_op_unit_bench;

  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          instrValid;
  logic [6:0]    opcodeIn;
  logic [2:0]    funct3In;
  logic [6:0]    immSrcIn;
  logic [4:0]    immDstIn;
  logic [AW-1:0] rs1Val;
  logic [AW-1:0] rs2Val;
  logic          stallIn;
  logic          doneOut, illegalOut, busyOut;
  logic          fmRdEn, fmWrEn, wtRdEn, wtWrEn;
  logic          arrPushEn, arrEvalEn, arrRdEn, arrWrEn;
  logic [AW-1:0] fmRdAddr, fmWrAddr, wtRdAddr, wtWrAddr, arrAddr;
  logic [DW-1:0] fmRdData, fmWrData, wtRdData, wtWrData;
  logic [DW-1:0] arrInData, arrResult, arrRdData, arrWrData;

  always #5 clk = ~clk;

  // Memory and array models: data is a known function of the address.
  assign fmRdData  = 32'hA500_0000 | 32'(fmRdAddr);
  assign wtRdData  = 32'h5A00_0000 | (32'(wtRdAddr) << 8);
  assign arrRdData = 32'h3C00_0000 | 32'(arrAddr);
  assign arrResult = ~arrInData;

  cim_op_unit u_cim_op_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .opcodeIn(opcodeIn),
    .funct3In(funct3In), .immSrcIn(immSrcIn), .immDstIn(immDstIn),
    .rs1Val(rs1Val), .rs2Val(rs2Val), .stallIn(stallIn),
    .doneOut(doneOut), .illegalOut(illegalOut), .busyOut(busyOut),
    .fmRdEn(fmRdEn), .fmRdAddr(fmRdAddr), .fmRdData(fmRdData),
    .fmWrEn(fmWrEn), .fmWrAddr(fmWrAddr), .fmWrData(fmWrData),
    .wtRdEn(wtRdEn), .wtRdAddr(wtRdAddr), .wtRdData(wtRdData),
    .wtWrEn(wtWrEn), .wtWrAddr(wtWrAddr), .wtWrData(wtWrData),
    .arrPushEn(arrPushEn), .arrInData(arrInData), .arrEvalEn(arrEvalEn),
    .arrResult(arrResult), .arrRdEn(arrRdEn), .arrWrEn(arrWrEn),
    .arrAddr(arrAddr), .arrRdData(arrRdData), .arrWrData(arrWrData)
  );

  int nChk = 0;
  int nBad = 0;
  bit summaryDone = 1'b0;

  logic [7:0] enVec;
  assign enVec = {fmRdEn, fmWrEn, wtRdEn, wtWrEn, arrPushEn, arrEvalEn, arrRdEn, arrWrEn};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] wrapAdd(input logic [7:0] base, input int off);
    int s;
    s = int'(base) + off;
    return s[7:0];
  endfunction

  function automatic int sx7(input logic [6:0] v);
    return v[6] ? int'(v) - 128 : int'(v);
  endfunction

  function automatic int sx5(input logic [4:0] v);
    return v[4] ? int'(v) - 32 : int'(v);
  endfunction

  // Enable pattern order: fmRd fmWr wtRd wtWr arrPush arrEval arrRd arrWr
  function automatic logic [7:0] expEn(input logic [2:0] f3);
    case (f3)
      3'd0:    return 8'b1100_1100;
      3'd1:    return 8'b0001_0010;
      3'd2:    return 8'b0010_0001;
      default: return 8'b0000_0000;
    endcase
  endfunction

  task automatic drive(input logic v, input logic [6:0] opc, input logic [2:0] f3,
                       input logic [6:0] hi, input logic [4:0] lo,
                       input logic [7:0] r1, input logic [7:0] r2, input logic st);
    instrValid = v;  opcodeIn = opc; funct3In = f3;
    immSrcIn   = hi; immDstIn = lo;  rs1Val   = r1; rs2Val = r2; stallIn = st;
  endtask

  task automatic checkExec(input string tag, input logic [2:0] f3,
                           input logic [7:0] src, input logic [7:0] dst);
    chk({tag, " enables"}, 32'(enVec), 32'(expEn(f3)));
    chk({tag, " R9 done"}, 32'(doneOut), 32'd1);
    case (f3)
      3'd0: begin
        chk({tag, " R2 fm src addr"}, 32'(fmRdAddr), 32'(src));
        chk({tag, " R2 fm dst addr"}, 32'(fmWrAddr), 32'(dst));
        chk({tag, " R3 push data"}, arrInData, 32'hA500_0000 | 32'(src));
        chk({tag, " R3 result data"}, fmWrData, ~(32'hA500_0000 | 32'(src)));
      end
      3'd1: begin
        chk({tag, " R2 arr src addr"}, 32'(arrAddr), 32'(src));
        chk({tag, " R2 wt dst addr"}, 32'(wtWrAddr), 32'(dst));
        chk({tag, " R4 weight data"}, wtWrData, 32'h3C00_0000 | 32'(src));
      end
      default: begin
        chk({tag, " R2 wt src addr"}, 32'(wtRdAddr), 32'(src));
        chk({tag, " R2 arr dst addr"}, 32'(arrAddr), 32'(dst));
        chk({tag, " R5 word data"}, arrWrData, 32'h5A00_0000 | (32'(src) << 8));
      end
    endcase
  endtask

  task automatic checkQuiet(input string tag);
    chk({tag, " no strobes"}, 32'(enVec), 32'd0);
    chk({tag, " no done"}, 32'(doneOut), 32'd0);
  endtask

  localparam logic [6:0] OPC = 7'b1111110;

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] r1s [4];
    logic [6:0] his [5];
    logic [7:0] src, dst, r2;
    logic [4:0] lo;
    string tag;
    r1s = '{8'h00, 8'h05, 8'hFA, 8'hFF};
    his = '{7'h00, 7'h01, 7'h7F, 7'h40, 7'h3F};

    rstN = 1'b0;
    drive(1'b0, 7'd0, 3'd0, 7'd0, 5'd0, 8'd0, 8'd0, 1'b0);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy in reset", 32'(busyOut), 32'd0);
    checkQuiet("R10 reset");
    chk("R10 illegal in reset", 32'(illegalOut), 32'd0);
    rstN = 1'b1;
    step();

    // Sweep of funct3, base values and immediate signs (R2..R6, R9)
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 5; b++) begin
          lo  = 5'(f * 5 + a * 3 + b * 7);
          r2  = r1s[a] ^ 8'h3C ^ 8'(b);
          src = wrapAdd(r1s[a], sx7(his[b]));
          dst = wrapAdd(r2, sx5(lo));
          drive(1'b1, OPC, 3'(f), his[b], lo, r1s[a], r2, 1'b0);
          #2;
          if (f == 0)      tag = "R3 conv";
          else if (f == 1) tag = "R4 read";
          else if (f == 2) tag = "R5 write";
          else             tag = "R6 illegal";
          if (f < 3) checkExec(tag, 3'(f), src, dst);
          else       checkQuiet(tag);
          chk({tag, " illegal flag"}, 32'(illegalOut), (f > 2) ? 32'd1 : 32'd0);
          step();
          chk({tag, " R7 busy stays low"}, 32'(busyOut), 32'd0);
        end
      end
    end

    // R1: foreign opcodes and invalid cycles
    drive(1'b1, 7'b0110011, 3'd0, 7'd3, 5'd3, 8'd9, 8'd9, 1'b0);
    #2;
    checkQuiet("R1 foreign opcode");
    chk("R1 foreign illegal", 32'(illegalOut), 32'd0);
    step();
    drive(1'b1, 7'b1111111, 3'd1, 7'd3, 5'd3, 8'd9, 8'd9, 1'b0);
    #2;
    checkQuiet("R1 near opcode");
    step();
    drive(1'b0, OPC, 3'd0, 7'd3, 5'd3, 8'd9, 8'd9, 1'b0);
    #2;
    checkQuiet("R1 valid low");
    chk("R1 valid low illegal", 32'(illegalOut), 32'd0);
    step();

    // R6: illegal under stall
    drive(1'b1, OPC, 3'd5, 7'd1, 5'd1, 8'd1, 8'd1, 1'b1);
    #2;
    chk("R6 illegal under stall", 32'(illegalOut), 32'd1);
    checkQuiet("R6 illegal under stall");
    step();
    chk("R6 no capture", 32'(busyOut), 32'd0);

    // R7/R8: capture a conv under stall, then a different op waits on the inputs
    drive(1'b1, OPC, 3'd0, 7'h7E, 5'h1F, 8'h01, 8'h00, 1'b1);
    #2;
    checkQuiet("R7 stalled conv");
    chk("R7 busy before edge", 32'(busyOut), 32'd0);
    step();
    chk("R7 busy after capture", 32'(busyOut), 32'd1);
    drive(1'b1, OPC, 3'd2, 7'h10, 5'h04, 8'h80, 8'h40, 1'b1);
    for (int k = 0; k < 3; k++) begin
      #2;
      checkQuiet("R7 held stall");
      chk("R8 still busy", 32'(busyOut), 32'd1);
      step();
    end
    stallIn = 1'b0;
    #2;
    // captured: src = 0x01 + (-2) = 0xFF, dst = 0x00 + (-1) = 0xFF
    checkExec("R8 release conv", 3'd0, 8'hFF, 8'hFF);
    chk("R8 illegal ignored while busy", 32'(illegalOut), 32'd0);
    step();
    chk("R8 busy cleared", 32'(busyOut), 32'd0);
    #2;
    checkExec("R8 waiting write", 3'd2, 8'h90, 8'h44);
    step();

    // R8: inputs ignored while busy, including an illegal funct3
    drive(1'b1, OPC, 3'd1, 7'h02, 5'h03, 8'h10, 8'h20, 1'b1);
    step();
    drive(1'b1, OPC, 3'd7, 7'h00, 5'h00, 8'h00, 8'h00, 1'b1);
    #2;
    chk("R8 illegal hidden while busy", 32'(illegalOut), 32'd0);
    step();
    drive(1'b0, OPC, 3'd7, 7'h00, 5'h00, 8'h00, 8'h00, 1'b0);
    #2;
    checkExec("R8 release read", 3'd1, 8'h12, 8'h23);
    step();

    // R10: reset discards a held operation
    drive(1'b1, OPC, 3'd2, 7'h05, 5'h05, 8'h05, 8'h05, 1'b1);
    step();
    chk("R10 busy before reset", 32'(busyOut), 32'd1);
    rstN = 1'b0;
    #1;
    chk("R10 busy cleared by reset", 32'(busyOut), 32'd0);
    step();
    rstN = 1'b1;
    drive(1'b0, OPC, 3'd0, 7'd0, 5'd0, 8'd0, 8'd0, 1'b0);
    #2;
    checkQuiet("R10 nothing replayed");
    step();

    report();
  end

endmodule